// File: doc/BRIEF.md
# Sequenced Floating-Point Matrix-Vector Product Generator

This block accepts one job made of a 3x3 matrix and a 3-element vector, all in single-precision floating-point format, and emits the nine element-wise products M(r,c)*V(c) as a stream, one product per clock. A single 24x24 mantissa multiplier is shared by all nine products. Each product is built from the XOR of the operand signs, the sum of the operand exponents minus the bias of 127, and the 48-bit mantissa product. That product is renormalized with at most a one-bit shift and then truncated. The stream feeds a downstream summation stage, which is not part of this block.

Jobs arrive on a valid/ready handshake. A job is taken on a clock edge where `job_valid` and `job_ready` are both high. The block then runs a fixed frame of 10 clocks. `job_ready` goes high again only in the last slot of the frame, or while the block is idle. A producer that holds `job_valid` high while `job_ready` is low is not queued and simply waits. The output stream has a valid flag and no ready, so the consumer must take every product in the cycle it appears; there is no back-pressure on the output.

Word layout on every operand: bit 31 is the sign, bits 30:23 are the biased exponent, and bits 22:0 are the fraction. Matrix element (r,c) sits at bits [(3r+c)*32 +: 32] of `job_mat`, and vector element c sits at bits [c*32 +: 32] of `job_vec`. Inputs are assumed normalized and in range. Zeros, denormals, infinities, NaNs and exponent overflow are not treated specially.

Top module: `fpmv_product_seq`

## Requirements
- R1: While reset is held and after it is released, before any job is taken, `job_ready` is 1 and `prod_valid` is 0.
- R2: `job_ready` is 1 only while idle or in the final (10th) clock of a frame. A job is taken only on an edge where `job_valid` and `job_ready` are both 1. A request made while `job_ready` is 0 is ignored and produces no products.
- R3: The products of a job are emitted in the order (row 0: col 0,1,2), (row 1: col 0,1,2), (row 2: col 0,1,2). Each product carries `prod_row` = r and `prod_col` = c as plain binary.
- R4: The first product of a job has `prod_valid` = 1 after the third rising edge following the accepting edge. The nine products occupy nine consecutive cycles, and `prod_valid` is 0 in every cycle that holds no product.
- R5: `prod_sign` is the XOR of bit 31 of the two operands.
- R6: `prod_exp` is the low 8 bits of ea + eb - 127 + s, where ea and eb are the operand exponent fields and s is the renormalization shift (0 or 1) from R7.
- R7: With P = {1,fa} * {1,fb} as a 48-bit product, if P[47] = 1 then `prod_mant` = P[47:24] and s = 1; otherwise `prod_mant` = P[46:23] and s = 0. `prod_mant` includes the hidden bit (bit 23), and the dropped bits are truncated.
- R8: With `job_valid` held at 1, a new job is taken every 10 clocks. The output then shows nine valid cycles followed by exactly one empty cycle, repeated.
- R9: Operands are captured on the accepting edge. Changes on `job_mat` or `job_vec` afterwards do not affect that job's products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| job_valid | input | 1 | Job request |
| job_ready | output | 1 | Job can be taken this cycle |
| job_mat | input | 288 | Nine matrix words, element (r,c) at [(3r+c)*32 +: 32] |
| job_vec | input | 96 | Three vector words, element c at [c*32 +: 32] |
| prod_valid | output | 1 | A product is present this cycle |
| prod_sign | output | 1 | Product sign |
| prod_exp | output | 8 | Biased product exponent |
| prod_mant | output | 24 | Product mantissa including hidden bit |
| prod_row | output | 2 | Matrix row of the product |
| prod_col | output | 2 | Matrix column / vector index of the product |

## Verification
Two things can land in the same cycle: a new job being taken in the final frame slot, and the earlier job's last products still moving through the multiply and renormalize stages. Holding `job_valid` high continuously forces this overlap in every frame. The bench then checks that the old products come out intact, that the new job's first product follows after exactly one empty cycle, and that operand words randomized on every clock never leak into a job in flight. A second overlap is a mid-frame request arriving while the block is busy. Sparse and random request patterns provoke it, and the per-cycle model confirms that such a request adds no products and does not shift the frame.

// File: rtl/fpmv_pkg.sv
package fpmv_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W;
  localparam int unsigned MANT_W = FRAC_W + 1;
  localparam int unsigned PROD_W = 2 * MANT_W;
  localparam int unsigned EXPS_W = EXP_W + 2;
  localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1;

  typedef struct packed {
    logic              sign;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } fp_word_t;
endpackage

// File: rtl/fpmv_sequencer.sv
module fpmv_sequencer
  import fpmv_pkg::*;
#(
  parameter int unsigned DIM       = 3,
  parameter int unsigned FRAME_LEN = 10,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        job_valid,
  output logic                        job_ready,
  input  logic [DIM*DIM*WORD_W-1:0]   job_mat,
  input  logic [DIM*WORD_W-1:0]       job_vec,
  output logic                        op_valid,
  output fp_word_t                    op_a,
  output fp_word_t                    op_b,
  output logic [IDX_W-1:0]            op_row,
  output logic [IDX_W-1:0]            op_col
);
  localparam int unsigned N_PROD = DIM * DIM;
  localparam int unsigned CNT_W  = $clog2(FRAME_LEN);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] ISSUE_END = CNT_W'(N_PROD);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DIM - 1);

  logic                      busy;
  logic [CNT_W-1:0]          slot;
  logic [IDX_W-1:0]          row_q, col_q;
  logic [N_PROD*WORD_W-1:0]  mat_q;
  logic [DIM*WORD_W-1:0]     vec_q;
  fp_word_t                  mat_arr [DIM][DIM];
  fp_word_t                  vec_arr [DIM];
  logic                      accept, issue;

  // Unpack captured operands into indexable arrays.
  for (genvar r = 0; r < DIM; r++) begin : g_row
    for (genvar c = 0; c < DIM; c++) begin : g_col
      assign mat_arr[r][c] = mat_q[(r*DIM+c)*WORD_W +: WORD_W];
    end
    assign vec_arr[r] = vec_q[r*WORD_W +: WORD_W];
  end

  assign job_ready = !busy || (slot == LAST_SLOT);
  assign accept    = job_valid && job_ready;
  assign issue     = busy && (slot < ISSUE_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      slot  <= '0;
      row_q <= '0;
      col_q <= '0;
    end else if (accept) begin
      busy  <= 1'b1;
      slot  <= '0;
      row_q <= '0;
      col_q <= '0;
    end else if (busy) begin
      if (slot == LAST_SLOT) begin
        busy <= 1'b0;
      end else begin
        slot <= slot + 1'b1;
      end
      if (issue) begin
        if (col_q == IDX_LAST) begin
          col_q <= '0;
          row_q <= row_q + 1'b1;
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mat_q <= job_mat;
      vec_q <= job_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_a     <= '0;
      op_b     <= '0;
      op_row   <= '0;
      op_col   <= '0;
    end else begin
      op_valid <= issue;
      if (issue) begin
        op_a   <= mat_arr[row_q][col_q];
        op_b   <= vec_arr[col_q];
        op_row <= row_q;
        op_col <= col_q;
      end
    end
  end

  // R2: a taken job restarts the frame at slot zero, first element.
  p_accept_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && slot == '0 && row_q == '0 && col_q == '0));

  // R8: inside a frame the slot counter steps by one each clock.
  p_frame_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot != LAST_SLOT) |=> (busy && slot == CNT_W'($past(slot) + 1'b1)));

  // R9: captured operands hold for the whole frame.
  p_operands_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slot != LAST_SLOT) |=> ($stable(mat_q) && $stable(vec_q)));
endmodule

// File: rtl/fpmv_mant_mul.sv
module fpmv_mant_mul
  import fpmv_pkg::*;
#(
  parameter int unsigned IDX_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  fp_word_t                 in_a,
  input  fp_word_t                 in_b,
  input  logic [IDX_W-1:0]         in_row,
  input  logic [IDX_W-1:0]         in_col,
  output logic                     out_valid,
  output logic                     out_sign,
  output logic [EXPS_W-1:0]        out_exp,
  output logic [PROD_W-1:0]        out_prod,
  output logic [IDX_W-1:0]         out_row,
  output logic [IDX_W-1:0]         out_col
);
  logic [MANT_W-1:0] mant_a, mant_b;
  logic [EXPS_W-1:0] exp_sum;

  assign mant_a  = {1'b1, in_a.frac};
  assign mant_b  = {1'b1, in_b.frac};
  assign exp_sum = EXPS_W'(in_a.expo) + EXPS_W'(in_b.expo) - EXPS_W'(BIAS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sign  <= 1'b0;
      out_exp   <= '0;
      out_prod  <= '0;
      out_row   <= '0;
      out_col   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign <= in_a.sign ^ in_b.sign;
        out_exp  <= exp_sum;
        out_prod <= PROD_W'(mant_a) * PROD_W'(mant_b);
        out_row  <= in_row;
        out_col  <= in_col;
      end
    end
  end

  // R4: every issued operand pair yields exactly one multiply result.
  p_valid_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R7: normalized mantissas give a product in [2^46, 2^48).
  p_prod_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_prod[PROD_W-1] || out_prod[PROD_W-2]));
endmodule

// File: rtl/fpmv_renorm.sv
module fpmv_renorm
  import fpmv_pkg::*;
#(
  parameter int unsigned DIM   = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sign,
  input  logic [EXPS_W-1:0]    in_exp,
  input  logic [PROD_W-1:0]    in_prod,
  input  logic [IDX_W-1:0]     in_row,
  input  logic [IDX_W-1:0]     in_col,
  output logic                 out_valid,
  output logic                 out_sign,
  output logic [EXP_W-1:0]     out_exp,
  output logic [MANT_W-1:0]    out_mant,
  output logic [IDX_W-1:0]     out_row,
  output logic [IDX_W-1:0]     out_col
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DIM - 1);

  logic              carry;
  logic [MANT_W-1:0] mant_sel;
  logic [EXPS_W-1:0] exp_adj;

  assign carry    = in_prod[PROD_W-1];
  assign mant_sel = carry ? in_prod[PROD_W-1 -: MANT_W] : in_prod[PROD_W-2 -: MANT_W];
  assign exp_adj  = in_exp + EXPS_W'(carry);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sign  <= 1'b0;
      out_exp   <= '0;
      out_mant  <= '0;
      out_row   <= '0;
      out_col   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign <= in_sign;
        out_exp  <= exp_adj[EXP_W-1:0];
        out_mant <= mant_sel;
        out_row  <= in_row;
        out_col  <= in_col;
      end
    end
  end

  // R7: every emitted mantissa carries its hidden bit.
  p_hidden_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_mant[MANT_W-1]);

  // R3: within a row the column index steps by one on consecutive cycles.
  p_col_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_col != '0) |->
      ($past(out_valid) && out_col == IDX_W'($past(out_col) + 1'b1) && out_row == $past(out_row)));

  // R3: a new row begins right after the previous row's last column.
  p_row_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_col == '0 && out_row != '0) |->
      ($past(out_valid) && $past(out_col) == IDX_LAST && out_row == IDX_W'($past(out_row) + 1'b1)));
endmodule

// File: rtl/fpmv_product_seq.sv
module fpmv_product_seq
  import fpmv_pkg::*;
#(
  parameter int unsigned DIM       = 3,
  parameter int unsigned FRAME_LEN = 10,
  parameter int unsigned IDX_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       job_valid,
  output logic                       job_ready,
  input  logic [DIM*DIM*32-1:0]      job_mat,
  input  logic [DIM*32-1:0]          job_vec,
  output logic                       prod_valid,
  output logic                       prod_sign,
  output logic [7:0]                 prod_exp,
  output logic [23:0]                prod_mant,
  output logic [IDX_W-1:0]           prod_row,
  output logic [IDX_W-1:0]           prod_col
);
  // FRAME_LEN must be at least DIM*DIM + 1; the default word is single precision.
  logic              s1_valid;
  fp_word_t          s1_a, s1_b;
  logic [IDX_W-1:0]  s1_row, s1_col;

  logic              s2_valid, s2_sign;
  logic [EXPS_W-1:0] s2_exp;
  logic [PROD_W-1:0] s2_prod;
  logic [IDX_W-1:0]  s2_row, s2_col;

  fpmv_sequencer #(.DIM(DIM), .FRAME_LEN(FRAME_LEN), .IDX_W(IDX_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .job_valid (job_valid),
    .job_ready (job_ready),
    .job_mat   (job_mat),
    .job_vec   (job_vec),
    .op_valid  (s1_valid),
    .op_a      (s1_a),
    .op_b      (s1_b),
    .op_row    (s1_row),
    .op_col    (s1_col)
  );

  fpmv_mant_mul #(.IDX_W(IDX_W)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s1_valid),
    .in_a      (s1_a),
    .in_b      (s1_b),
    .in_row    (s1_row),
    .in_col    (s1_col),
    .out_valid (s2_valid),
    .out_sign  (s2_sign),
    .out_exp   (s2_exp),
    .out_prod  (s2_prod),
    .out_row   (s2_row),
    .out_col   (s2_col)
  );

  fpmv_renorm #(.DIM(DIM), .IDX_W(IDX_W)) u_norm (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s2_valid),
    .in_sign   (s2_sign),
    .in_exp    (s2_exp),
    .in_prod   (s2_prod),
    .in_row    (s2_row),
    .in_col    (s2_col),
    .out_valid (prod_valid),
    .out_sign  (prod_sign),
    .out_exp   (prod_exp),
    .out_mant  (prod_mant),
    .out_row   (prod_row),
    .out_col   (prod_col)
  );

  // R1: nothing is emitted in the cycle right after reset.
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !prod_valid);
endmodule

// File: tb/fpmv_product_seq_bench.sv
module fpmv_product_seq_bench;
  typedef struct packed {
    logic        s;
    logic [7:0]  e;
    logic [23:0] m;
    logic [1:0]  row;
    logic [1:0]  col;
  } prod_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         job_valid = 1'b0;
  logic         job_ready;
  logic [287:0] job_mat = '0;
  logic [95:0]  job_vec = '0;
  logic         prod_valid, prod_sign;
  logic [7:0]   prod_exp;
  logic [23:0]  prod_mant;
  logic [1:0]   prod_row, prod_col;

  int    cyc = 0;
  int    n_vec = 0;
  int    n_bad = 0;
  int    next_ready = 0;
  prod_t exp_q [int];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  fpmv_product_seq u_fpmv_product_seq (
    .clk(clk), .rst_n(rst_n), .job_valid(job_valid), .job_ready(job_ready),
    .job_mat(job_mat), .job_vec(job_vec), .prod_valid(prod_valid),
    .prod_sign(prod_sign), .prod_exp(prod_exp), .prod_mant(prod_mant),
    .prod_row(prod_row), .prod_col(prod_col)
  );

  function automatic logic [31:0] rand_word(input int mode);
    logic [22:0] f;
    logic [7:0]  e;
    e = 8'(110 + ($urandom % 31));
    if (mode == 1)      f = '1;
    else if (mode == 2) f = '0;
    else                f = 23'($urandom);
    return {1'($urandom), e, f};
  endfunction

  function automatic prod_t model(input logic [31:0] a, input logic [31:0] b,
                                  input int r, input int c);
    prod_t       p;
    longint      ma, mb, pr;
    int          sh, ex;
    ma = longint'({1'b1, a[22:0]});
    mb = longint'({1'b1, b[22:0]});
    pr = ma * mb;
    sh = int'((pr >> 47) & 1);
    p.s = a[31] ^ b[31];
    ex = int'(a[30:23]) + int'(b[30:23]) - 127 + sh;
    p.e = 8'(ex);
    p.m = (sh == 1) ? 24'(pr >> 24) : 24'(pr >> 23);
    p.row = 2'(r);
    p.col = 2'(c);
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, expv);
    end
  endtask

  task automatic compare_cycle();
    bit    rdy_exp;
    prod_t e;
    rdy_exp = (cyc >= next_ready);
    check(job_ready == rdy_exp, "R2", "job_ready", longint'(job_ready), longint'(rdy_exp));
    if (exp_q.exists(cyc)) begin
      e = exp_q[cyc];
      exp_q.delete(cyc);
      check(prod_valid == 1'b1, "R4", "prod_valid", longint'(prod_valid), 1);
      if (prod_valid) begin
        check(prod_row == e.row && prod_col == e.col, "R3", "row/col",
              longint'({prod_row, prod_col}), longint'({e.row, e.col}));
        check(prod_sign == e.s, "R5", "sign", longint'(prod_sign), longint'(e.s));
        check(prod_exp == e.e, "R6", "exponent", longint'(prod_exp), longint'(e.e));
        check(prod_mant == e.m, "R7", "mantissa", longint'(prod_mant), longint'(e.m));
      end
    end else begin
      check(prod_valid == 1'b0, "R4", "idle prod_valid", longint'(prod_valid), 0);
    end
  endtask

  task automatic drive(input int i);
    int mode;
    mode = (i == 0) ? 1 : ((i == 13) ? 2 : 0);
    for (int k = 0; k < 9; k++) job_mat[k*32 +: 32] = rand_word(mode);
    for (int k = 0; k < 3; k++) job_vec[k*32 +: 32] = rand_word(mode);
    if (i < 150)      job_valid = (i % 13 == 0) || (i % 7 == 3);  // sparse, many mid-frame (R2)
    else if (i < 450) job_valid = 1'b1;                          // back-to-back frames (R8)
    else              job_valid = ($urandom % 3 == 0);
    // Operands are re-randomized every cycle, so a leak of later words shows (R9).
    if (job_valid && cyc >= next_ready) begin
      for (int r = 0; r < 3; r++)
        for (int c = 0; c < 3; c++)
          exp_q[cyc + 4 + r*3 + c] = model(job_mat[(r*3+c)*32 +: 32], job_vec[c*32 +: 32], r, c);
      next_ready = cyc + 10;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) begin
      @(negedge clk);
      check(job_ready == 1'b1 && prod_valid == 1'b0, "R1", "reset state",
            longint'({job_ready, prod_valid}), 2);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check(job_ready == 1'b1 && prod_valid == 1'b0, "R1", "after reset",
          longint'({job_ready, prod_valid}), 2);
    next_ready = cyc;
    for (int i = 0; i < 700; i++) begin
      compare_cycle();
      drive(i);
      @(negedge clk);
    end
    job_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      compare_cycle();
      @(negedge clk);
    end
    check(exp_q.num() == 0, "R4", "products never emitted", longint'(exp_q.num()), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule